// File: doc/BRIEF.md
# Power-Mode Sequencer for a Line-Powered Node

This block decides whether a node on a shared supply line is awake, asleep or half-awake. It watches three wake sources: the host's active-low sleep request, a local wake pin and a strobe from the modem saying a remote wakeup message was heard. It drives the inhibit output that powers the host. It also forces the host data-out line low whenever the host must be told that a wakeup is in progress.

While asleep, the block opens a short listening window once per polling period, so that the receiver only has to run for part of the time. When the node wakes on its own, it asks the modem to send a wakeup message and waits for a done strobe. An idle timer puts the node to sleep after a long stretch with no received bus data, when the host has enabled that timer. Every interval is counted in ticks of a prescaled clock, so one netlist serves any time base.

A fourth, transient state covers the start-up delay after reset. The current mode is presented on a 2-bit output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the mode is Normal, a high-to-low change on `sleep_n` moves the block to Sleep on the next clock, and `inh` goes low. A low-to-high change on `sleep_n` while in Sleep is the only host action that leaves Sleep; a constant high `sleep_n` does not.
- R2: With `auto_sleep_n` low, Normal turns into Sleep after `IDLE_TICKS` ticks without a `bus_rx_strobe`. Each strobe restarts the count. With `auto_sleep_n` high, the block never leaves Normal on its own.
- R3: A rise of `sleep_n` in Sleep enters Standby with `inh` high and `wake_req` high, and `hdo` held low. On `wake_done`, `wake_req` falls and the mode becomes Normal when `sleep_n` is high.
- R4: Either a rising or a falling edge on `wake_pin` in Sleep starts the same wakeup send as R3. The pin passes through a two-stage synchronizer before edge detection, so the mode changes three clocks after the pin.
- R5: `sniff_en` is high only in Sleep. It is high for the last `SNIFF_TICKS` ticks of every `POLL_TICKS`-tick period, counted from entry to Sleep, so it rises once per `POLL_TICKS` ticks.
- R6: `bus_wake_det` is acted on only while `sniff_en` is high. It enters Standby with `inh` high and `hdo` low and no `wake_req`. `hdo` stays low for at least `SIG_MIN_TICKS` ticks, even if `sleep_n` is already high. It is released after `SIG_MAX_TICKS` ticks if the host has not raised `sleep_n`.
- R7: In Standby with no send and no host signalling pending, the block stays in Standby until `sleep_n` is high, and then enters Normal.
- R8: After reset the mode is Boot, and it becomes Normal after `BOOT_TICKS` ticks. Boot is never entered again.
- R9: `pwr_mode` is encoded as 0 Normal, 1 Sleep, 2 Standby, 3 Boot. `inh` is low only in Sleep. In Normal, `hdo` follows `modem_hdo`. In Sleep, and in Standby outside wakeup signalling, `hdo` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Host sleep request, low asks for Sleep |
| wake_pin | input | 1 | Local wake input, asynchronous, either edge wakes |
| bus_wake_det | input | 1 | Strobe: remote wakeup message detected |
| bus_rx_strobe | input | 1 | Strobe: valid data received from the bus |
| auto_sleep_n | input | 1 | Idle-timer enable, active low |
| modem_hdo | input | 1 | Received data headed for the host |
| wake_done | input | 1 | Strobe: outgoing wakeup message finished |
| inh | output | 1 | Host power enable, low in Sleep |
| hdo | output | 1 | Host data-out line |
| wake_req | output | 1 | Request to transmit a wakeup message |
| sniff_en | output | 1 | Bus listening window while asleep |
| pwr_mode | output | 2 | Current mode code |

## Verification
The bench pulses `bus_wake_det` outside the listening window. A design that did not gate the strobe would wake. It also raises `sleep_n` right after a bus wakeup, which catches a design that releases `hdo` before the minimum signalling time. It holds `sleep_n` low through a bus wakeup to catch a design that never releases `hdo`, or that enters Normal without the host. After an idle-timer sleep, `sleep_n` stays high; a design that treated a high level as a wake request would leave Sleep at once. Finally, the bench measures the distance between two rises of `sniff_en`, which exposes an off-by-one in the polling counter.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   typedef enum logic [2:0] {
      S_BOOT   = 3'd0,
      S_NORM   = 3'd1,
      S_SLEEP  = 3'd2,
      S_SEND   = 3'd3,
      S_BUSSIG = 3'd4,
      S_HOLD   = 3'd5
   } pwr_state_t;

   localparam logic [1:0] MODE_NORMAL  = 2'd0;
   localparam logic [1:0] MODE_SLEEP   = 2'd1;
   localparam logic [1:0] MODE_STANDBY = 2'd2;
   localparam logic [1:0] MODE_BOOT    = 2'd3;

   function automatic int unsigned pw_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned pw_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned CW = pwr_pkg::pw_bits(DIV - 1);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/pwr_edge_sync.sv
module pwr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic any_edge
);
   logic [STAGES:0] pipe;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], din};
   end
   assign any_edge = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/pwr_span_timer.sv
module pwr_span_timer #(
   parameter int unsigned W     = 8,
   parameter int unsigned LIMIT = 100,
   parameter bit          WRAP  = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = W'(LIMIT);
   localparam logic [W-1:0] END = W'(LIMIT - 1);

   logic [W-1:0] cnt_inc;

   generate
      if (WRAP) begin : g_wrap
         assign cnt_inc = (cnt == END) ? '0 : cnt + 1'b1;
      end else begin : g_sat
         assign cnt_inc = (cnt == TOP) ? cnt : cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt_inc;
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_pkg::*;
#(
   parameter int unsigned TICK_DIV      = 1000,
   parameter int unsigned BOOT_TICKS    = 6,
   parameter int unsigned IDLE_TICKS    = 8000,
   parameter int unsigned POLL_TICKS    = 32,
   parameter int unsigned SNIFF_TICKS   = 1,
   parameter int unsigned SIG_MIN_TICKS = 1,
   parameter int unsigned SIG_MAX_TICKS = 150,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_n,
   input  logic       wake_pin,
   input  logic       bus_wake_det,
   input  logic       bus_rx_strobe,
   input  logic       auto_sleep_n,
   input  logic       modem_hdo,
   input  logic       wake_done,
   output logic       inh,
   output logic       hdo,
   output logic       wake_req,
   output logic       sniff_en,
   output logic [1:0] pwr_mode
);
   localparam int unsigned TLIM = pw_max(BOOT_TICKS, SIG_MAX_TICKS);
   localparam int unsigned TW   = pw_bits(TLIM);
   localparam int unsigned IW   = pw_bits(IDLE_TICKS);
   localparam int unsigned PW   = pw_bits(POLL_TICKS);

   localparam logic [TW-1:0] BOOT_LAST = TW'(BOOT_TICKS - 1);
   localparam logic [TW-1:0] SIG_MIN   = TW'(SIG_MIN_TICKS);
   localparam logic [TW-1:0] SIG_MAX   = TW'(SIG_MAX_TICKS);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_TICKS - 1);
   localparam logic [PW-1:0] SNIFF_AT  = PW'(POLL_TICKS - SNIFF_TICKS);

   pwr_state_t    state, state_nxt;
   logic          tick;
   logic          wake_edge;
   logic          sleep_q;
   logic          sleep_fall, sleep_rise;
   logic          idle_run, idle_exp;
   logic [TW-1:0] tcnt;
   logic [IW-1:0] icnt;
   logic [PW-1:0] pcnt;

   pwr_tick_gen #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   pwr_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (wake_pin),
      .any_edge(wake_edge)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sleep_q <= 1'b1;
      else        sleep_q <= sleep_n;
   end
   assign sleep_fall = sleep_q & ~sleep_n;
   assign sleep_rise = ~sleep_q & sleep_n;

   // state time: cleared on every state change
   pwr_span_timer #(.W(TW), .LIMIT(TLIM), .WRAP(1'b0)) u_tstate (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (state_nxt != state),
      .step (tick),
      .cnt  (tcnt)
   );

   // idle time since last received bus data
   assign idle_run = (state == S_NORM) && !auto_sleep_n;
   pwr_span_timer #(.W(IW), .LIMIT(IDLE_TICKS), .WRAP(1'b0)) u_tidle (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!idle_run || bus_rx_strobe),
      .step (tick),
      .cnt  (icnt)
   );
   assign idle_exp = idle_run && !bus_rx_strobe && tick && (icnt == IDLE_LAST);

   // polling phase while asleep
   pwr_span_timer #(.W(PW), .LIMIT(POLL_TICKS), .WRAP(1'b1)) u_tpoll (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (state != S_SLEEP),
      .step (tick),
      .cnt  (pcnt)
   );
   assign sniff_en = (state == S_SLEEP) && (pcnt >= SNIFF_AT);

   always_comb begin
      state_nxt = state;
      unique case (state)
         S_BOOT:   if (tick && tcnt == BOOT_LAST) state_nxt = S_NORM;
         S_NORM:   if (sleep_fall || idle_exp) state_nxt = S_SLEEP;
         S_SLEEP: begin
            if (sleep_rise || wake_edge)        state_nxt = S_SEND;
            else if (sniff_en && bus_wake_det)  state_nxt = S_BUSSIG;
         end
         S_SEND:   if (wake_done) state_nxt = sleep_n ? S_NORM : S_HOLD;
         S_BUSSIG: begin
            if (tcnt >= SIG_MIN && sleep_n) state_nxt = S_NORM;
            else if (tcnt >= SIG_MAX)       state_nxt = S_HOLD;
         end
         S_HOLD:   if (sleep_n) state_nxt = S_NORM;
         default:  state_nxt = S_BOOT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_BOOT;
      else        state <= state_nxt;
   end

   always_comb begin
      inh      = 1'b1;
      hdo      = 1'b1;
      wake_req = 1'b0;
      pwr_mode = MODE_STANDBY;
      unique case (state)
         S_BOOT:   pwr_mode = MODE_BOOT;
         S_NORM: begin
            pwr_mode = MODE_NORMAL;
            hdo      = modem_hdo;
         end
         S_SLEEP: begin
            pwr_mode = MODE_SLEEP;
            inh      = 1'b0;
         end
         S_SEND: begin
            wake_req = 1'b1;
            hdo      = 1'b0;
         end
         S_BUSSIG: hdo = 1'b0;
         default:  pwr_mode = MODE_STANDBY;
      endcase
   end
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
   import pwr_pkg::*;
#(
   parameter int unsigned BOOT_TICKS    = 6,
   parameter int unsigned IDLE_TICKS    = 8000,
   parameter int unsigned POLL_TICKS    = 32,
   parameter int unsigned SNIFF_TICKS   = 1,
   parameter int unsigned SIG_MIN_TICKS = 1,
   parameter int unsigned SIG_MAX_TICKS = 150,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_n,
   input logic       wake_done,
   input logic       inh,
   input logic       hdo,
   input logic       wake_req,
   input logic       sniff_en,
   input logic [1:0] pwr_mode
);
   initial begin
      AST_CFG_BOOT:  assert (BOOT_TICKS >= 1) else $error("boot interval must be at least one tick"); // R8
      AST_CFG_IDLE:  assert (IDLE_TICKS >= 1) else $error("idle interval must be at least one tick"); // R2
      AST_CFG_SNIFF: assert (SNIFF_TICKS >= 1 && SNIFF_TICKS < POLL_TICKS) else $error("listen window must be shorter than the poll period"); // R5
      AST_CFG_SIG:   assert (SIG_MIN_TICKS >= 1 && SIG_MIN_TICKS <= SIG_MAX_TICKS) else $error("signalling bounds out of order"); // R6
      AST_CFG_SYNC:  assert (SYNC_STAGES >= 2) else $error("synchronizer needs two stages"); // R4
   end

   AST_FALL_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == MODE_NORMAL && $fell(sleep_n)) |=> (pwr_mode == MODE_SLEEP && !inh)); // R1

   AST_SEND_HDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (!hdo && inh)); // R3

   AST_REQ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && wake_done) |=> !wake_req); // R3

   AST_SNIFF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      sniff_en |-> (pwr_mode == MODE_SLEEP)); // R5

   AST_STANDBY_WAITS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == MODE_STANDBY && !sleep_n) |=> (pwr_mode != MODE_NORMAL)); // R7

   AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode != MODE_BOOT) |=> (pwr_mode != MODE_BOOT)); // R8
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(
   .BOOT_TICKS   (BOOT_TICKS),
   .IDLE_TICKS   (IDLE_TICKS),
   .POLL_TICKS   (POLL_TICKS),
   .SNIFF_TICKS  (SNIFF_TICKS),
   .SIG_MIN_TICKS(SIG_MIN_TICKS),
   .SIG_MAX_TICKS(SIG_MAX_TICKS),
   .SYNC_STAGES  (SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sleep_n  (sleep_n),
   .wake_done(wake_done),
   .inh      (inh),
   .hdo      (hdo),
   .wake_req (wake_req),
   .sniff_en (sniff_en),
   .pwr_mode (pwr_mode)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 4;
   localparam int BOOT  = 6;
   localparam int IDLE  = 40;
   localparam int POLL  = 10;
   localparam int SNIFF = 2;
   localparam int SMIN  = 3;
   localparam int SMAX  = 12;

   localparam int M_NORM = 0, M_SLEEP = 1, M_STBY = 2, M_BOOT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_n = 1'b1, wake_pin = 1'b0, bus_wake_det = 1'b0, bus_rx_strobe = 1'b0;
   logic auto_sleep_n = 1'b1, modem_hdo = 1'b1, wake_done = 1'b0;
   logic inh, hdo, wake_req, sniff_en;
   logic [1:0] pwr_mode;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwr_mode_ctrl #(
      .TICK_DIV(DIV), .BOOT_TICKS(BOOT), .IDLE_TICKS(IDLE), .POLL_TICKS(POLL),
      .SNIFF_TICKS(SNIFF), .SIG_MIN_TICKS(SMIN), .SIG_MAX_TICKS(SMAX), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .wake_pin(wake_pin),
      .bus_wake_det(bus_wake_det), .bus_rx_strobe(bus_rx_strobe),
      .auto_sleep_n(auto_sleep_n), .modem_hdo(modem_hdo), .wake_done(wake_done),
      .inh(inh), .hdo(hdo), .wake_req(wake_req), .sniff_en(sniff_en), .pwr_mode(pwr_mode)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_done();
      wake_done = 1'b1; cycles(1); wake_done = 1'b0;
   endtask

   task automatic wait_sniff_rise(output int at);
      at = -1;
      for (int i = 0; i < 200 && at < 0; i++) begin
         @(negedge clk);
         if (sniff_en) at = cyc;
      end
   endtask

   task automatic go_sleep();
      sleep_n = 1'b0; cycles(2);
   endtask

   task automatic t_reset();
      cycles(1);
      chk("R8 mode after reset", pwr_mode, M_BOOT);
      chk("R9 inh in boot", inh, 1);
      chk("R3 no request in boot", wake_req, 0);
      cycles((BOOT-1)*DIV - 3);
      chk("R8 still booting", pwr_mode, M_BOOT);
      cycles(2*DIV + 2);
      chk("R8 normal after boot", pwr_mode, M_NORM);
   endtask

   task automatic t_host_sleep();
      modem_hdo = 1'b0; cycles(1);
      chk("R9 hdo follows modem low", hdo, 0);
      modem_hdo = 1'b1; cycles(1);
      chk("R9 hdo follows modem high", hdo, 1);
      sleep_n = 1'b0; cycles(1);
      chk("R1 sleep on fall", pwr_mode, M_SLEEP);
      chk("R1 inh low asleep", inh, 0);
      modem_hdo = 1'b0; cycles(1);
      chk("R9 hdo high asleep", hdo, 1);
      sleep_n = 1'b1; cycles(2);
      chk("R3 standby on rise", pwr_mode, M_STBY);
      chk("R3 request raised", wake_req, 1);
      chk("R3 hdo held low", hdo, 0);
      chk("R3 inh raised", inh, 1);
      cycles(10);
      chk("R3 request held until done", wake_req, 1);
      pulse_done(); cycles(1);
      chk("R3 normal after done", pwr_mode, M_NORM);
      chk("R3 request dropped", wake_req, 0);
      modem_hdo = 1'b1;
   endtask

   task automatic t_local_wake();
      go_sleep();
      wake_pin = 1'b1; cycles(5);
      chk("R4 rising wake edge", pwr_mode, M_STBY);
      chk("R4 request on wake", wake_req, 1);
      chk("R4 hdo low on wake", hdo, 0);
      pulse_done(); cycles(1);
      chk("R7 standby after done, host low", pwr_mode, M_STBY);
      chk("R9 hdo released in standby", hdo, 1);
      cycles(20);
      chk("R7 standby holds", pwr_mode, M_STBY);
      sleep_n = 1'b1; cycles(2);
      chk("R7 normal after host rise", pwr_mode, M_NORM);
      go_sleep();
      wake_pin = 1'b0; cycles(5);
      chk("R4 falling wake edge", wake_req, 1);
      sleep_n = 1'b1; cycles(1);
      pulse_done(); cycles(1);
      chk("R4 normal when host high", pwr_mode, M_NORM);
   endtask

   task automatic t_sniff();
      int r1, r2;
      go_sleep();
      chk("R5 window closed on entry", sniff_en, 0);
      bus_wake_det = 1'b1; cycles(1); bus_wake_det = 1'b0; cycles(1);
      chk("R6 strobe ignored outside window", pwr_mode, M_SLEEP);
      wait_sniff_rise(r1);
      for (int i = 0; i < 50 && sniff_en; i++) cycles(1);
      wait_sniff_rise(r2);
      chk("R5 poll period cycles", r2 - r1, POLL*DIV);
      bus_wake_det = 1'b1; cycles(1); bus_wake_det = 1'b0;
      chk("R6 standby on bus wake", pwr_mode, M_STBY);
      chk("R6 hdo low on bus wake", hdo, 0);
      chk("R6 no send on bus wake", wake_req, 0);
      cycles(40);
      chk("R6 hdo low until host or max", hdo, 0);
      cycles(10);
      chk("R6 hdo released at max", hdo, 1);
      chk("R7 still standby", pwr_mode, M_STBY);
      sleep_n = 1'b1; cycles(2);
      chk("R7 normal after bus wake", pwr_mode, M_NORM);
   endtask

   task automatic t_bus_min();
      int r;
      go_sleep();
      wait_sniff_rise(r);
      bus_wake_det = 1'b1; cycles(1); bus_wake_det = 1'b0;
      sleep_n = 1'b1;
      cycles((SMIN-1)*DIV - 1);
      chk("R6 hdo low for minimum", hdo, 0);
      chk("R6 standby during minimum", pwr_mode, M_STBY);
      cycles(DIV + 4);
      chk("R6 normal after minimum", pwr_mode, M_NORM);
   endtask

   task automatic t_auto_sleep();
      auto_sleep_n = 1'b1;
      cycles(250);
      chk("R2 disabled idle timer", pwr_mode, M_NORM);
      auto_sleep_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
         cycles(100);
         bus_rx_strobe = 1'b1; cycles(1); bus_rx_strobe = 1'b0;
      end
      chk("R2 rx keeps node awake", pwr_mode, M_NORM);
      cycles(140);
      chk("R2 not yet idle", pwr_mode, M_NORM);
      cycles(35);
      chk("R2 idle sleep", pwr_mode, M_SLEEP);
      auto_sleep_n = 1'b1;
      cycles(30);
      chk("R1 high level does not wake", pwr_mode, M_SLEEP);
      sleep_n = 1'b0; cycles(2);
      sleep_n = 1'b1; cycles(2);
      chk("R3 rise wakes after idle sleep", wake_req, 1);
      pulse_done(); cycles(1);
      chk("R3 back to normal", pwr_mode, M_NORM);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      t_reset();
      t_host_sleep();
      t_local_wake();
      t_sniff();
      t_bus_min();
      t_auto_sleep();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule